// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the shared register bank at the front of a DMA controller with up to twelve channels. A host reaches it through a simple 32-bit word-addressed register port. It holds each channel's 2-bit operating mode and its transfer direction bit. It also holds one interrupt enable per channel. From the channel engines it takes completion and error strobes and a live 2-bit activity state, and it presents them in two status words.

Channels 0 to 7 share one control word and one status word. Channels 8 to 11 sit in a second pair of words, and their bit positions are irregular. The bank sends a one-cycle start strobe to a channel whenever its stored mode leaves the disabled state. It also drives one combined interrupt line.

Each channel has a 16-byte window of descriptor registers. These registers live in the channel engines. This bank only decodes their addresses, forwards writes to the right engine, and returns that engine's read data.

The register port carries no handshake. A write takes effect at the clock edge where `bus_wr` is high. A read is captured at the edge where `bus_rd` is high. The port never applies back-pressure.

Top module: `dma_csr_regs`

## Requirements
- R1: After reset every channel's mode is 0 (disabled) and its direction is 0. All enables, pending flags and error flags are 0. `irq`, `ch_start` and `bus_rdata` are 0.
- R2: A write to offset 0x00 updates channels 0 to 7, using nibble 4n for channel n. A write to offset 0x0C updates channels 8 to 11, using nibble 4(n-8). In each nibble, bits 1:0 are the mode (0 disabled, 1 chained, 2 single) and bit 2 is the direction. Reading back returns these fields at the same positions, with bit 3 of each nibble and all unused bits reading 0.
- R3: A nibble whose mode bits are 3 leaves that channel's mode and direction unchanged, whatever its direction bit holds.
- R4: Offset 0x08 holds the interrupt enables. Channel n (0 to 7) uses bit n and channel n (8 to 11) uses bit n+8. All other bits read 0 and writes to them are ignored.
- R5: A high `ch_done[n]` sets channel n's pending flag. A high `ch_err[n]` sets both its error flag and its pending flag. In the word at 0x10, channel n (0 to 7) shows its pending flag at bit n and its error flag at bit n+8. In the word at 0x18, channel n (8 to 11) shows its pending flag at bit n-8 and its error flag at bit n.
- R6: Writing 1 to a pending or error bit clears it, and writing 0 leaves it as it is. If a set strobe and a clearing write reach the same flag in the same cycle, the set wins.
- R7: The status words show each channel's live `ch_state` at bits 16+2k and 17+2k, where k is n for channels 0 to 7 and n-8 for channels 8 to 11.
- R8: `irq` is high exactly when some channel has both its pending flag and its enable set. It follows the stored registers.
- R9: `ch_start[n]` is high for one cycle, in the cycle after a write moves channel n's stored mode from 0 to 1 or 2. Changing between 1 and 2, or rewriting the same mode, gives no strobe.
- R10: Channel n's descriptor window is the 16 bytes at 0x20+16n. A write there raises only `desc_wr[n]`, in the same cycle, with `desc_word` equal to address bits 3:2 and `desc_wdata` equal to `bus_wdata`. A read there returns channel n's `desc_rdata`. Offsets 0x04, 0x14, 0x1C and addresses past the last window read as 0 and raise no `desc_wr`.
- R11: `bus_rdata` is registered. It presents the read in the cycle after `bus_rd` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_done | input | NUM_CH | Per-channel completion strobe |
| ch_err | input | NUM_CH | Per-channel error strobe |
| ch_state | input | 2*NUM_CH | Live 2-bit activity state per channel |
| ch_mode | output | 2*NUM_CH | Stored mode per channel |
| ch_dir | output | NUM_CH | Stored direction per channel |
| ch_start | output | NUM_CH | One-cycle start strobe per channel |
| desc_wr | output | NUM_CH | Descriptor write strobe, one-hot |
| desc_word | output | 2 | Word index within a descriptor window |
| desc_wdata | output | 32 | Descriptor write data |
| desc_rdata | input | 32*NUM_CH | Descriptor read data from each channel |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach from the ports are the collisions. One is a set strobe from a channel landing in the same cycle as a write that clears that flag. Another is a keep-code write that carries a direction bit which must be discarded. A third is a mode change between the two active values, which must not strobe start.

The stimulus builds each collision on purpose. It times a done strobe into the cycle of the clearing write. It writes words that hold 3 in almost every nibble. It walks one channel from disabled to chained, then to single, then back to disabled.

A behavioural model of the register bank runs beside the design. Every clock it compares the modes, directions, start strobes, interrupt and read data, so any stray change in an untouched channel shows at once.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int REG_W  = 32;
  localparam int MAX_CH = 12;
  localparam int LO_CH  = 8;

  localparam int OFF_CTL0  = 'h00;
  localparam int OFF_CTL1  = 'h04;
  localparam int OFF_CTL2  = 'h08;
  localparam int OFF_CTL3  = 'h0C;
  localparam int OFF_STS0  = 'h10;
  localparam int OFF_STS1  = 'h14;
  localparam int OFF_STS2  = 'h18;
  localparam int OFF_DESC  = 'h20;
  localparam int DESC_SPAN = 16;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_KEEP   = 2'd3
  } ch_mode_e;

  // position of a channel inside its shared word
  function automatic int slot_of(int ch);
    return ch % LO_CH;
  endfunction

  function automatic int ien_pos(int ch);
    return (ch < LO_CH) ? ch : ch + 8;
  endfunction

  function automatic int err_pos(int ch);
    return slot_of(ch) + 8;
  endfunction

  function automatic int state_pos(int ch);
    return 16 + 2 * slot_of(ch);
  endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit_ctl0,
  output logic              hit_ctl2,
  output logic              hit_ctl3,
  output logic              hit_sts0,
  output logic              hit_sts2,
  output logic [NUM_CH-1:0] desc_hit
);

  logic [ADDR_W-3:0] word_idx;
  assign word_idx = bus_addr[ADDR_W-1:2];

  localparam logic [ADDR_W-1:0] A_CTL0 = ADDR_W'(OFF_CTL0);
  localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(OFF_CTL2);
  localparam logic [ADDR_W-1:0] A_CTL3 = ADDR_W'(OFF_CTL3);
  localparam logic [ADDR_W-1:0] A_STS0 = ADDR_W'(OFF_STS0);
  localparam logic [ADDR_W-1:0] A_STS2 = ADDR_W'(OFF_STS2);

  assign hit_ctl0 = (word_idx == A_CTL0[ADDR_W-1:2]);
  assign hit_ctl2 = (word_idx == A_CTL2[ADDR_W-1:2]);
  assign hit_ctl3 = (word_idx == A_CTL3[ADDR_W-1:2]);
  assign hit_sts0 = (word_idx == A_STS0[ADDR_W-1:2]);
  assign hit_sts2 = (word_idx == A_STS2[ADDR_W-1:2]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(OFF_DESC + DESC_SPAN * g);
    assign desc_hit[g] = (bus_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
  end

endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [2:0] ctl_nib,
  input  logic       ien_wr,
  input  logic       ien_val,
  input  logic       sts_wr,
  input  logic       clr_pend,
  input  logic       clr_err,
  input  logic       set_done,
  input  logic       set_err,
  output logic [1:0] mode,
  output logic       dir,
  output logic       ien,
  output logic       pend,
  output logic       err,
  output logic       start
);

  ch_mode_e mode_q, mode_d;
  logic     dir_q, dir_d;
  logic     ien_q, pend_q, err_q, start_q, start_d;
  logic     take_nib;

  assign take_nib = ctl_wr && (ctl_nib[1:0] != MODE_KEEP);

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    if (take_nib) begin
      mode_d = ch_mode_e'(ctl_nib[1:0]);
      dir_d  = ctl_nib[2];
    end
    start_d = (mode_q == MODE_OFF) &&
              ((mode_d == MODE_CHAIN) || (mode_d == MODE_SINGLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      dir_q   <= 1'b0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      dir_q   <= dir_d;
      start_q <= start_d;
      if (ien_wr) ien_q <= ien_val;
      pend_q <= set_done | set_err | (pend_q & ~(sts_wr & clr_pend));
      err_q  <= set_err | (err_q & ~(sts_wr & clr_err));
    end
  end

  assign mode  = mode_q;
  assign dir   = dir_q;
  assign ien   = ien_q;
  assign pend  = pend_q;
  assign err   = err_q;
  assign start = start_q;

  // R9: a strobe only follows a step out of the disabled mode
  p_start_from_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (mode_q != MODE_OFF) && ($past(mode_q) == MODE_OFF));

  // R3: the keep code touches neither mode nor direction
  p_keep_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_nib[1:0] == MODE_KEEP) |=> ($stable(mode_q) && $stable(dir_q)));

  // R5: any strobe leaves the flag pending
  p_strobe_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_done || set_err) |=> pend_q);

  // R6: a one written back clears the flag when no strobe competes
  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && clr_pend && !set_done && !set_err) |=> !pend_q);

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                    hit_ctl0,
  input  logic                    hit_ctl2,
  input  logic                    hit_ctl3,
  input  logic                    hit_sts0,
  input  logic                    hit_sts2,
  input  logic [NUM_CH-1:0]       desc_hit,
  input  logic [2*NUM_CH-1:0]     mode_vec,
  input  logic [NUM_CH-1:0]       dir_vec,
  input  logic [NUM_CH-1:0]       ien_vec,
  input  logic [NUM_CH-1:0]       pend_vec,
  input  logic [NUM_CH-1:0]       err_vec,
  input  logic [2*NUM_CH-1:0]     state_vec,
  input  logic [REG_W*NUM_CH-1:0] desc_rdata,
  output logic [REG_W-1:0]        rd_word
);

  logic [REG_W-1:0] w_ctl0, w_ctl2, w_ctl3, w_sts0, w_sts2, w_desc;

  always_comb begin
    w_ctl0 = '0;
    w_ctl2 = '0;
    w_ctl3 = '0;
    w_sts0 = '0;
    w_sts2 = '0;
    w_desc = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      w_ctl2[ien_pos(c)] = ien_vec[c];
      if (c < LO_CH) begin
        w_ctl0[4*slot_of(c) +: 3]   = {dir_vec[c], mode_vec[2*c +: 2]};
        w_sts0[slot_of(c)]          = pend_vec[c];
        w_sts0[err_pos(c)]          = err_vec[c];
        w_sts0[state_pos(c) +: 2]   = state_vec[2*c +: 2];
      end else begin
        w_ctl3[4*slot_of(c) +: 3]   = {dir_vec[c], mode_vec[2*c +: 2]};
        w_sts2[slot_of(c)]          = pend_vec[c];
        w_sts2[err_pos(c)]          = err_vec[c];
        w_sts2[state_pos(c) +: 2]   = state_vec[2*c +: 2];
      end
      if (desc_hit[c]) w_desc = w_desc | desc_rdata[REG_W*c +: REG_W];
    end
  end

  always_comb begin
    if (hit_ctl0)      rd_word = w_ctl0;
    else if (hit_ctl2) rd_word = w_ctl2;
    else if (hit_ctl3) rd_word = w_ctl3;
    else if (hit_sts0) rd_word = w_sts0;
    else if (hit_sts2) rd_word = w_sts2;
    else               rd_word = w_desc;
  end

endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]       ch_done,
  input  logic [NUM_CH-1:0]       ch_err,
  input  logic [2*NUM_CH-1:0]     ch_state,
  output logic [2*NUM_CH-1:0]     ch_mode,
  output logic [NUM_CH-1:0]       ch_dir,
  output logic [NUM_CH-1:0]       ch_start,
  output logic [NUM_CH-1:0]       desc_wr,
  output logic [1:0]              desc_word,
  output logic [REG_W-1:0]        desc_wdata,
  input  logic [REG_W*NUM_CH-1:0] desc_rdata,
  output logic                    irq
);

  logic hit_ctl0, hit_ctl2, hit_ctl3, hit_sts0, hit_sts2;
  logic [NUM_CH-1:0] desc_hit;
  logic [NUM_CH-1:0] ien_vec, pend_vec, err_vec;
  logic [REG_W-1:0]  rd_word, rdata_q;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^bus_addr[1:0];

  dma_csr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .bus_addr (bus_addr),
    .hit_ctl0 (hit_ctl0),
    .hit_ctl2 (hit_ctl2),
    .hit_ctl3 (hit_ctl3),
    .hit_sts0 (hit_sts0),
    .hit_sts2 (hit_sts2),
    .desc_hit (desc_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int SLOT = g % LO_CH;
    localparam int IEN  = (g < LO_CH) ? g : g + 8;
    logic ctl_sel, sts_sel;
    assign ctl_sel = (g < LO_CH) ? hit_ctl0 : hit_ctl3;
    assign sts_sel = (g < LO_CH) ? hit_sts0 : hit_sts2;

    dma_csr_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (bus_wr && ctl_sel),
      .ctl_nib  (bus_wdata[4*SLOT +: 3]),
      .ien_wr   (bus_wr && hit_ctl2),
      .ien_val  (bus_wdata[IEN]),
      .sts_wr   (bus_wr && sts_sel),
      .clr_pend (bus_wdata[SLOT]),
      .clr_err  (bus_wdata[SLOT+8]),
      .set_done (ch_done[g]),
      .set_err  (ch_err[g]),
      .mode     (ch_mode[2*g +: 2]),
      .dir      (ch_dir[g]),
      .ien      (ien_vec[g]),
      .pend     (pend_vec[g]),
      .err      (err_vec[g]),
      .start    (ch_start[g])
    );
  end

  dma_csr_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .hit_ctl0   (hit_ctl0),
    .hit_ctl2   (hit_ctl2),
    .hit_ctl3   (hit_ctl3),
    .hit_sts0   (hit_sts0),
    .hit_sts2   (hit_sts2),
    .desc_hit   (desc_hit),
    .mode_vec   (ch_mode),
    .dir_vec    (ch_dir),
    .ien_vec    (ien_vec),
    .pend_vec   (pend_vec),
    .err_vec    (err_vec),
    .state_vec  (ch_state),
    .desc_rdata (desc_rdata),
    .rd_word    (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata  = rdata_q;
  assign desc_wr    = desc_hit & {NUM_CH{bus_wr}};
  assign desc_word  = bus_addr[3:2];
  assign desc_wdata = bus_wdata;
  assign irq        = |(pend_vec & ien_vec);

  // R11: read data only moves on a read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R8: an interrupt needs some flag and some enable
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|pend_vec) && (|ien_vec)));

  // R10: at most one descriptor window is written
  p_desc_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(desc_wr));

endmodule

// File: tb/tb_dma_csr_regs.sv
`timescale 1ns/1ps
module tb_dma_csr_regs;

  localparam int NCH = 12;
  localparam int AW  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    ch_done = '0, ch_err = '0;
  logic [2*NCH-1:0]  ch_state = '0;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH-1:0]    ch_dir, ch_start, desc_wr;
  logic [1:0]        desc_word;
  logic [31:0]       desc_wdata;
  logic [32*NCH-1:0] desc_rdata;
  logic              irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  always_comb begin
    for (int n = 0; n < NCH; n++)
      desc_rdata[32*n +: 32] = 32'hA500_0000 | (32'(n) << 8) | 32'(desc_word);
  end

  dma_csr_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_done(ch_done), .ch_err(ch_err), .ch_state(ch_state),
    .ch_mode(ch_mode), .ch_dir(ch_dir), .ch_start(ch_start),
    .desc_wr(desc_wr), .desc_word(desc_word), .desc_wdata(desc_wdata),
    .desc_rdata(desc_rdata), .irq(irq)
  );

  // behavioural reference state
  logic [1:0] m_mode [NCH];
  logic       m_dir  [NCH];
  logic       m_ien  [NCH];
  logic       m_pend [NCH];
  logic       m_err  [NCH];
  logic       m_start[NCH];
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r;
    logic [7:0]  w;
    r = '0;
    w = {a[7:2], 2'b00};
    if (w == 8'h00) begin
      for (int n = 0; n < 8; n++) r[4*n +: 3] = {m_dir[n], m_mode[n]};
    end else if (w == 8'h0C) begin
      for (int n = 8; n < NCH; n++) r[4*(n-8) +: 3] = {m_dir[n], m_mode[n]};
    end else if (w == 8'h08) begin
      for (int n = 0; n < NCH; n++) r[(n < 8) ? n : n + 8] = m_ien[n];
    end else if (w == 8'h10) begin
      for (int n = 0; n < 8; n++) begin
        r[n] = m_pend[n]; r[n+8] = m_err[n]; r[16+2*n +: 2] = ch_state[2*n +: 2];
      end
    end else if (w == 8'h18) begin
      for (int n = 8; n < NCH; n++) begin
        r[n-8] = m_pend[n]; r[n] = m_err[n]; r[16+2*(n-8) +: 2] = ch_state[2*n +: 2];
      end
    end else if (int'(a) >= 'h20 && int'(a) < 'h20 + 16*NCH) begin
      r = 32'hA500_0000 | (32'((int'(a) - 'h20) / 16) << 8) | 32'(a[3:2]);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdata <= '0;
      for (int n = 0; n < NCH; n++) begin
        m_mode[n] <= 2'd0; m_dir[n] <= 1'b0; m_ien[n] <= 1'b0;
        m_pend[n] <= 1'b0; m_err[n] <= 1'b0; m_start[n] <= 1'b0;
      end
    end else begin
      if (bus_rd) m_rdata <= m_read(bus_addr);
      for (int n = 0; n < NCH; n++) begin
        int slot;
        logic [7:0] w;
        logic [3:0] nib;
        logic hitc, hits, st;
        slot = n % 8;
        w    = {bus_addr[7:2], 2'b00};
        nib  = bus_wdata[4*slot +: 4];
        hitc = bus_wr && (w == ((n < 8) ? 8'h00 : 8'h0C));
        hits = bus_wr && (w == ((n < 8) ? 8'h10 : 8'h18));
        st   = 1'b0;
        if (hitc && nib[1:0] != 2'd3) begin
          m_mode[n] <= nib[1:0];
          m_dir[n]  <= nib[2];
          st = (m_mode[n] == 2'd0) && (nib[1:0] != 2'd0);
        end
        m_start[n] <= st;
        if (bus_wr && w == 8'h08) m_ien[n] <= bus_wdata[(n < 8) ? n : n + 8];
        m_pend[n] <= ch_done[n] | ch_err[n] | (m_pend[n] & !(hits && bus_wdata[slot]));
        m_err[n]  <= ch_err[n] | (m_err[n] & !(hits && bus_wdata[slot+8]));
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic any_irq;
      logic [NCH-1:0] exp_dw;
      any_irq = 1'b0;
      for (int n = 0; n < NCH; n++) begin
        any_irq = any_irq | (m_pend[n] & m_ien[n]);
        exp_dw[n] = bus_wr && (int'(bus_addr) >= 'h20 + 16*n) && (int'(bus_addr) < 'h30 + 16*n);
        chk(ch_mode[2*n +: 2] == m_mode[n], "R2", "mode", 32'(ch_mode[2*n +: 2]), 32'(m_mode[n]));
        chk(ch_dir[n] == m_dir[n], "R2", "dir", 32'(ch_dir[n]), 32'(m_dir[n]));
        chk(ch_start[n] == m_start[n], "R9", "start", 32'(ch_start[n]), 32'(m_start[n]));
      end
      chk(bus_rdata == m_rdata, cur_req, "rdata", bus_rdata, m_rdata);
      chk(irq == any_irq, "R8", "irq", 32'(irq), 32'(any_irq));
      chk(desc_wr == exp_dw, "R10", "desc_wr", 32'(desc_wr), 32'(exp_dw));
      chk(desc_word == bus_addr[3:2], "R10", "desc_word", 32'(desc_word), 32'(bus_addr[3:2]));
      chk(desc_wdata == bus_wdata, "R10", "desc_wdata", desc_wdata, bus_wdata);
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    @(posedge clk); #2;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ch_done = dn; ch_err = er;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1, 0, a, d, '0, '0); endtask
  task automatic rd(input logic [7:0] a); cyc(0, 1, a, '0, '0, '0); endtask
  task automatic idle(); cyc(0, 0, 8'h00, '0, '0, '0); endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(bus_rdata == 0, "R1", "reset rdata", bus_rdata, 0);
    chk(irq == 0, "R1", "reset irq", 32'(irq), 0);
    chk(ch_mode == 0 && ch_dir == 0, "R1", "reset ctl", 32'(ch_mode), 0);
    chk(ch_start == 0, "R1", "reset start", 32'(ch_start), 0);
    rd(8'h00); rd(8'h08); rd(8'h10); rd(8'h18);

    cur_req = "R2";
    wr(8'h00, 32'h2615_6152); rd(8'h00);
    wr(8'h0C, 32'h0000_5216); rd(8'h0C);
    wr(8'h0C, 32'hFFFF_DA9E); rd(8'h0C);

    cur_req = "R3";
    wr(8'h00, 32'hFFFF_FFF0); rd(8'h00);
    wr(8'h00, 32'h7777_7777); rd(8'h00);
    wr(8'h0C, 32'h0000_7773); rd(8'h0C);

    cur_req = "R9";
    wr(8'h00, 32'h3333_3331); idle();
    wr(8'h00, 32'h3333_3332); wr(8'h00, 32'h3333_3332);
    wr(8'h00, 32'h3333_3330); wr(8'h0C, 32'h0000_0000);
    wr(8'h0C, 32'h0000_1226); rd(8'h0C); idle();

    cur_req = "R4";
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08);
    wr(8'h08, 32'h0005_0005); rd(8'h08);

    cur_req = "R5";
    ch_state = 24'hE4_1B39;
    cyc(0, 0, 8'h00, '0, 12'h082, 12'h000); idle();
    cyc(0, 0, 8'h00, '0, 12'h000, 12'h200); idle();
    rd(8'h10); rd(8'h18);
    cyc(0, 0, 8'h00, '0, 12'h400, 12'h001); idle();
    rd(8'h10); rd(8'h18);

    cur_req = "R6";
    wr(8'h10, 32'h0000_0000); rd(8'h10);
    cyc(1, 0, 8'h10, 32'hFFFF_FFFF, 12'h001, 12'h000); rd(8'h10);
    wr(8'h18, 32'h0000_FFFF); rd(8'h18);
    wr(8'h10, 32'h0000_0001); rd(8'h10); idle();

    cur_req = "R7";
    ch_state = 24'h1B_E4C6; rd(8'h10); rd(8'h18);
    ch_state = 24'h00_FFFF; rd(8'h10); rd(8'h18);

    cur_req = "R8";
    cyc(0, 0, 8'h00, '0, 12'h002, 12'h000); idle();
    cyc(0, 0, 8'h00, '0, 12'h400, 12'h000); idle();
    wr(8'h08, 32'h0000_0000); idle();
    wr(8'h08, 32'h0004_0000); idle();
    wr(8'h18, 32'h0000_0F0F); idle();

    cur_req = "R10";
    wr(8'h20, 32'h1111_0000); wr(8'h74, 32'h2222_5555);
    wr(8'hDC, 32'h3333_BBBB); wr(8'hE0, 32'h4444_0000);
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h28); rd(8'h74); rd(8'hD4); rd(8'hE4);
    rd(8'h04); rd(8'h14); rd(8'h1C); rd(8'hFC);

    cur_req = "R11";
    rd(8'h00); idle(); idle();
    wr(8'h00, 32'h0000_0006); idle();
    cyc(0, 0, 8'h00, '0, 12'hFFF, 12'h000); idle();
    rd(8'h08); idle(); idle();

    repeat (3) idle();
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule